// File: doc/BRIEF.md
# Latching Limit Alert with Alert-Response Arbitration

This block watches the result words coming out of a sensor's conversion engine and raises an open-drain alert line whenever a result lies outside a programmable band. Each result is compared, as a signed number, against an upper and a lower limit. In latching mode a trip holds the alert until something clears it: a read of the conversion data, or this device winning an SMBus alert response. In non-latching mode the line simply shows the verdict on the most recent result.

When the bus master sees the shared alert line low, it reads from the alert response address. An I2C slave front end decodes that read and passes the decoded bus events to this block: reply start, SCL rising and falling strokes, the sampled SDA level, and the STOP condition. A device whose alert is asserted replies with its own 7-bit address followed by a status bit. Arbitration happens bit by bit on the wired-AND SDA line, so the lowest address wins. Only the winner clears its latch. Losers stay asserted and answer again when the master repeats the response.

Top module: `lim_alert`

## Requirements
- R1: After reset, both `alert_oe` and `sda_oe` are 0, so both lines are released.
- R2: An upper-limit trip occurs when the result, taken as two's complement, is strictly greater than `hi_lim`. A result equal to `hi_lim` does not trip, and a negative result never exceeds a positive limit.
- R3: A lower-limit trip (result strictly less than `lo_lim`, signed) raises the alert only when `win_en` is 1. With `win_en` at 0, only upper-limit trips count.
- R4: With `latch_en` at 1, the alert stays asserted through later in-range results until it is cleared.
- R5: With `latch_en` at 1, a `data_rd` pulse clears the alert. A later trip asserts it again. A trip and a `data_rd` in the same cycle leave the alert asserted.
- R6: With `latch_en` at 0, the alert follows the verdict on the latest result, and `data_rd` has no effect.
- R7: With `alert_en` at 0, `alert_oe` is 0. The tripped state is kept and shows again once `alert_en` returns to 1.
- R8: On `ara_start`, a device with its alert asserted sends the byte {address, status} MSB first. It pulls SDA low (`sda_oe`=1) for each 0 bit, and `sda_oe` changes only on `scl_fall`, `ara_start` or `bus_stop`. A device whose alert is not asserted leaves SDA released.
- R9: The status bit is 1 when the latest trip was on the upper limit and 0 when it was on the lower limit.
- R10: If the device releases SDA for a 1 bit but samples SDA low on `scl_rise`, it has lost arbitration. It releases SDA for the rest of the byte and its alert stays asserted.
- R11: A device that completes all 8 bits without losing wins, and its latched alert clears on the eighth `scl_rise`. A repeated response then lets the next device through.
- R12: `bus_stop` abandons a reply in progress: SDA is released at once and the alert is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_vld | input | 1 | New conversion result strobe |
| conv_res | input | RES_W | Conversion result, two's complement |
| hi_lim | input | RES_W | Upper limit, signed |
| lo_lim | input | RES_W | Lower limit, signed |
| latch_en | input | 1 | 1: latching alert, 0: follows latest result |
| win_en | input | 1 | 1: lower limit also trips |
| alert_en | input | 1 | Alert output enable |
| data_rd | input | 1 | Conversion data read strobe |
| ara_start | input | 1 | Front end accepted an alert-response read; reply begins |
| scl_rise | input | 1 | SCL rising-edge strobe |
| scl_fall | input | 1 | SCL falling-edge strobe |
| sda_in | input | 1 | Synchronised SDA level |
| bus_stop | input | 1 | STOP condition seen |
| alert_oe | output | 1 | Pull-down enable for the alert line |
| sda_oe | output | 1 | Pull-down enable for SDA during the reply |

## Verification
The hardest situation to reach is a contested reply: two asserted devices answering the same response, with one giving up partway through the byte. The bench models a second device and the wired-AND of the two SDA drivers. It drives the SCL strokes bit by bit and records the byte the master would see. It places the rival's address below ours to force a loss at the first bit, and just above ours to force a late win. It then repeats the response to confirm that the loser, and only the loser, still answers.

// File: rtl/lim_alert_pkg.sv
`timescale 1ns/1ps
package lim_alert_pkg;
   localparam int ADDR_W = 7;
   localparam int REPLY_W = ADDR_W + 1;

   // outcome of one limit comparison
   typedef struct packed {
      logic trip;   // result counts as an alert
      logic upper;  // result lies above the upper limit
   } cmp_res_t;
endpackage

// File: rtl/lim_alert_cmp.sv
`timescale 1ns/1ps
module lim_alert_cmp
   import lim_alert_pkg::*;
#(
   parameter int RES_W = 12,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [RES_W-1:0] res,
   input  logic [RES_W-1:0] hi,
   input  logic [RES_W-1:0] lo,
   input  logic             win_en,
   output cmp_res_t         verdict
);
   logic above, below;

   generate
      if (SIGNED_CMP) begin : g_signed
         assign above = $signed(res) > $signed(hi);
         assign below = $signed(res) < $signed(lo);
      end else begin : g_unsigned
         assign above = res > hi;
         assign below = res < lo;
      end
   endgenerate

   always_comb begin
      verdict.upper = above;
      verdict.trip  = above | (win_en & below);
   end
endmodule

// File: rtl/lim_alert_state.sv
`timescale 1ns/1ps
module lim_alert_state
   import lim_alert_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     conv_vld,
   input  cmp_res_t verdict,
   input  logic     latch_en,
   input  logic     clr_rd,
   input  logic     clr_win,
   output logic     alert_q,
   output logic     stat_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alert_q <= 1'b0;
         stat_q  <= 1'b0;
      end else if (latch_en) begin
         if (conv_vld && verdict.trip) begin
            alert_q <= 1'b1;
            stat_q  <= verdict.upper;
         end else if (clr_rd || clr_win) begin
            alert_q <= 1'b0;
         end
      end else if (conv_vld) begin
         alert_q <= verdict.trip;
         if (verdict.trip) stat_q <= verdict.upper;
      end
   end
endmodule

// File: rtl/lim_alert_reply.sv
`timescale 1ns/1ps
module lim_alert_reply
   import lim_alert_pkg::*;
#(
   parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic eligible,
   input  logic stat,
   input  logic scl_rise,
   input  logic scl_fall,
   input  logic sda_in,
   input  logic stop,
   output logic sda_oe,
   output logic won,
   output logic lost
);
   localparam int IDX_W = $clog2(REPLY_W);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(REPLY_W - 1);

   logic               act_q, lost_q;
   logic [REPLY_W-1:0] sh_q;
   logic [IDX_W-1:0]   idx_q;
   logic               clash;

   // released a 1 but the wire reads 0
   assign clash = sh_q[REPLY_W-1] & ~sda_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         lost_q <= 1'b0;
         sh_q   <= '1;
         idx_q  <= '0;
      end else if (stop) begin
         act_q  <= 1'b0;
         lost_q <= 1'b0;
      end else if (start) begin
         act_q  <= eligible;
         lost_q <= 1'b0;
         sh_q   <= {DEV_ADDR, stat};
         idx_q  <= '0;
      end else if (act_q) begin
         if (scl_rise && clash) lost_q <= 1'b1;
         if (scl_fall) begin
            if (idx_q == LAST) begin
               act_q  <= 1'b0;
               lost_q <= 1'b0;
            end else begin
               sh_q  <= {sh_q[REPLY_W-2:0], 1'b1};
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign sda_oe = act_q & ~lost_q & ~sh_q[REPLY_W-1];
   assign won    = act_q & ~lost_q & scl_rise & ~clash & (idx_q == LAST);
   assign lost   = lost_q;
endmodule

// File: rtl/lim_alert.sv
`timescale 1ns/1ps
module lim_alert
   import lim_alert_pkg::*;
#(
   parameter int RES_W = 12,
   parameter bit SIGNED_CMP = 1'b1,
   parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_vld,
   input  logic [RES_W-1:0] conv_res,
   input  logic [RES_W-1:0] hi_lim,
   input  logic [RES_W-1:0] lo_lim,
   input  logic             latch_en,
   input  logic             win_en,
   input  logic             alert_en,
   input  logic             data_rd,
   input  logic             ara_start,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_in,
   input  logic             bus_stop,
   output logic             alert_oe,
   output logic             sda_oe
);
   generate
      if (RES_W < 2) begin : g_bad_width
         $error("lim_alert: RES_W must be at least 2");
      end
      if (DEV_ADDR == 7'h0C) begin : g_bad_addr
         $error("lim_alert: DEV_ADDR may not equal the alert response address");
      end
   endgenerate

   cmp_res_t verdict;
   logic     alert_q, stat_q, ara_win, ara_lost;

   lim_alert_cmp #(.RES_W(RES_W), .SIGNED_CMP(SIGNED_CMP)) cmp_i (
      .res(conv_res), .hi(hi_lim), .lo(lo_lim), .win_en(win_en), .verdict(verdict)
   );

   lim_alert_state state_i (
      .clk(clk), .rst_n(rst_n), .conv_vld(conv_vld), .verdict(verdict),
      .latch_en(latch_en), .clr_rd(data_rd), .clr_win(ara_win),
      .alert_q(alert_q), .stat_q(stat_q)
   );

   lim_alert_reply #(.DEV_ADDR(DEV_ADDR)) reply_i (
      .clk(clk), .rst_n(rst_n), .start(ara_start), .eligible(alert_oe),
      .stat(stat_q), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
      .stop(bus_stop), .sda_oe(sda_oe), .won(ara_win), .lost(ara_lost)
   );

   assign alert_oe = alert_q & alert_en;
endmodule

// File: rtl/lim_alert_chk.sv
`timescale 1ns/1ps
module lim_alert_chk (
   input logic clk,
   input logic rst_n,
   input logic conv_vld,
   input logic latch_en,
   input logic alert_en,
   input logic data_rd,
   input logic ara_start,
   input logic scl_rise,
   input logic scl_fall,
   input logic sda_in,
   input logic bus_stop,
   input logic alert_oe,
   input logic sda_oe,
   input logic ara_win,
   input logic ara_lost
);
   // R4
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && alert_oe && !data_rd && !conv_vld && !ara_win) |=> (alert_oe || !alert_en));

   // R5
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && data_rd && !conv_vld) |=> !alert_oe);

   // R8
   sda_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> $past(scl_fall || ara_start || bus_stop));

   // R10
   lose_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ara_lost) |-> ($past(scl_rise) && !$past(sda_in) && !$past(sda_oe)));

   // R11
   win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ara_win && latch_en && !conv_vld) |=> !alert_oe);
endmodule

bind lim_alert lim_alert_chk chk_i (
   .clk(clk), .rst_n(rst_n), .conv_vld(conv_vld), .latch_en(latch_en),
   .alert_en(alert_en), .data_rd(data_rd), .ara_start(ara_start),
   .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .bus_stop(bus_stop),
   .alert_oe(alert_oe), .sda_oe(sda_oe), .ara_win(ara_win), .ara_lost(ara_lost)
);

// File: tb/lim_alert_tb_top.sv
`timescale 1ns/1ps
module lim_alert_tb_top;
   localparam int RW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv_vld = 1'b0, latch_en = 1'b1, win_en = 1'b0, alert_en = 1'b1;
   logic data_rd = 1'b0, ara_start = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
   logic bus_stop = 1'b0, oth_pull = 1'b0;
   logic [RW-1:0] conv_res = '0, hi_lim = 12'd100, lo_lim = 12'hF9C;
   logic alert_oe, sda_oe, sda_in;
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;
   assign sda_in = ~(sda_oe | oth_pull);

   lim_alert #(.RES_W(RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .conv_vld(conv_vld), .conv_res(conv_res),
      .hi_lim(hi_lim), .lo_lim(lo_lim), .latch_en(latch_en), .win_en(win_en),
      .alert_en(alert_en), .data_rd(data_rd), .ara_start(ara_start),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
      .bus_stop(bus_stop), .alert_oe(alert_oe), .sda_oe(sda_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // one result; optional read in the same cycle; sampled after the edge
   task automatic conv(input logic [RW-1:0] v, input logic rd);
      @(negedge clk); conv_vld = 1'b1; conv_res = v; data_rd = rd;
      @(negedge clk); conv_vld = 1'b0; data_rd = 1'b0; #1;
   endtask

   task automatic rd_pulse;
      @(negedge clk); data_rd = 1'b1;
      @(negedge clk); data_rd = 1'b0; #1;
   endtask

   // alert response with an optional rival; stop_at < 8 aborts after that many bits
   task automatic ara(input logic oth_en, input logic [7:0] oth_b, input int stop_at,
                      output logic [7:0] obs, output logic seen_oe);
      logic oth_lost;
      oth_lost = 1'b0; obs = 8'hFF; seen_oe = 1'b0;
      @(negedge clk); ara_start = 1'b1;
      @(negedge clk); ara_start = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (i == stop_at) begin
            bus_stop = 1'b1;
            @(negedge clk); bus_stop = 1'b0; oth_pull = 1'b0; #1;
            break;
         end
         oth_pull = oth_en & ~oth_b[7-i] & ~oth_lost;
         #1;
         obs[7-i] = sda_in;
         seen_oe = seen_oe | sda_oe;
         scl_rise = 1'b1;
         @(negedge clk); scl_rise = 1'b0; scl_fall = 1'b1;
         if (oth_en && oth_b[7-i] && !obs[7-i]) oth_lost = 1'b1;
         @(negedge clk); scl_fall = 1'b0;
      end
      oth_pull = 1'b0; #1;
   endtask

   task automatic t_reset;
      chk("R1 alert_oe after reset", alert_oe, 0);
      chk("R1 sda_oe after reset", sda_oe, 0);
   endtask

   task automatic t_upper;
      latch_en = 1'b0; win_en = 1'b0;
      conv(12'd100, 1'b0); chk("R2 equal to upper limit", alert_oe, 0);
      conv(12'd101, 1'b0); chk("R2 above upper limit", alert_oe, 1);
      conv(12'hFFB, 1'b0); chk("R2 negative vs positive limit", alert_oe, 0);
   endtask

   task automatic t_window;
      latch_en = 1'b0; win_en = 1'b0;
      conv(12'hF9B, 1'b0); chk("R3 low ignored outside window mode", alert_oe, 0);
      win_en = 1'b1;
      conv(12'hF9B, 1'b0); chk("R3 low trips in window mode", alert_oe, 1);
      conv(12'hF9C, 1'b0); chk("R3 equal to lower limit", alert_oe, 0);
   endtask

   task automatic t_nonlatch;
      latch_en = 1'b0; win_en = 1'b1;
      conv(12'd300, 1'b0); rd_pulse;
      chk("R6 read ignored without latch", alert_oe, 1);
      conv(12'd5, 1'b0); chk("R6 follows latest result", alert_oe, 0);
   endtask

   task automatic t_latch;
      latch_en = 1'b1;
      conv(12'd200, 1'b0); conv(12'd0, 1'b0);
      chk("R4 held through in-range result", alert_oe, 1);
      rd_pulse; chk("R5 read clears", alert_oe, 0);
      conv(12'd200, 1'b0); chk("R5 reasserts", alert_oe, 1);
      rd_pulse; conv(12'd200, 1'b1);
      chk("R5 trip beats same-cycle read", alert_oe, 1);
   endtask

   task automatic t_enable;
      alert_en = 1'b0; #1; chk("R7 disabled releases line", alert_oe, 0);
      @(negedge clk); alert_en = 1'b1; #1;
      chk("R7 state kept while disabled", alert_oe, 1);
   endtask

   task automatic t_reply;
      logic [7:0] o; logic s;
      latch_en = 1'b1; win_en = 1'b0;
      rd_pulse;
      ara(1'b0, 8'hFF, 8, o, s);
      chk("R8 idle device stays silent", {o, 7'd0, s}, {8'hFF, 8'd0});
      conv(12'd150, 1'b0);
      ara(1'b0, 8'hFF, 8, o, s);
      chk("R9 R8 upper reply byte", o, 8'h91);
      chk("R11 sole responder cleared", alert_oe, 0);
      win_en = 1'b1;
      conv(12'hF00, 1'b0);
      ara(1'b0, 8'hFF, 8, o, s);
      chk("R9 lower-limit status bit", o, 8'h90);
   endtask

   task automatic t_arbit;
      logic [7:0] o; logic s;
      latch_en = 1'b1; win_en = 1'b0;
      conv(12'd150, 1'b0);
      ara(1'b1, 8'h43, 8, o, s);
      chk("R10 lower rival wins wire", o, 8'h43);
      chk("R10 loser stays asserted", alert_oe, 1);
      ara(1'b1, 8'h95, 8, o, s);
      chk("R11 late win byte", o, 8'h91);
      chk("R11 winner cleared", alert_oe, 0);
   endtask

   task automatic t_stop;
      logic [7:0] o; logic s;
      conv(12'd150, 1'b0);
      ara(1'b0, 8'hFF, 1, o, s);
      chk("R12 SDA released after stop", sda_oe, 0);
      chk("R12 alert kept after stop", alert_oe, 1);
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report;
      $finish;
   end

   initial begin
      #1; t_reset;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_upper;
      t_window;
      t_nonlatch;
      t_latch;
      t_enable;
      t_reply;
      t_arbit;
      t_stop;
      report;
      $finish;
   end
endmodule